// File: doc/BRIEF.md
# Real-Signal Transform Split Stage

This block lets a half-length complex transform core (256 bins) stand in for a 512-point transform of a real signal. For every bin `i` it reads two complex samples from a working buffer, the sample at `i` and its mirror partner at `(256 - i) mod 256`, weights them with two complex coefficients `A(i)` and `B(i)`, and writes the combined complex result to a separate output buffer. In inverse mode it runs before the inverse transform; in forward mode it runs after the forward transform. Only the sign pattern of the weighting differs between the two directions.

One signed multiplier is shared by all eight products of a bin. A bin takes ten cycles: two buffer reads (sample, then partner) and eight multiply-accumulate steps, four for the real result and four for the imaginary result. The coefficient store sits outside the block and is read through a combinational port addressed by the bin number. The input buffer is read through a combinational port as well; results leave through a write port, so no input sample is overwritten while it may still be needed. A start pulse launches a pass over all 256 bins and a one-cycle done pulse follows the last write.

Coefficients are signed fractions with 15 fraction bits. Each result is the exact sum of four products, rounded half up at the 15-bit boundary and clamped to the 16-bit signed range.

Top module: `rfftSplit`

## Requirements
- R1: After reset `wrEn` and `done` are low and stay low until a pass is started.
- R2: With `inverseMode` = 1 at start, bin i is written with real part xi·ai + xr·ar + pr·br − pi·bi and imaginary part xi·ar − xr·ai − pr·bi − pi·br, where x = sample i, p = partner sample, a = A(i), b = B(i); all complex words carry the real part in bits [31:16] and the imaginary part in bits [15:0].
- R3: With `inverseMode` = 0 at start, bin i is written with real part −xi·ai + xr·ar + pr·br + pi·bi and imaginary part xi·ar + xr·ai + pr·bi − pi·br.
- R4: The partner of bin i is buffer entry (256 − i) mod 256, so bin 0 is paired with entry 0.
- R5: Each sum of four products is rounded by adding 2^14 and shifting right arithmetically by 15, then clamped to [−32768, 32767].
- R6: A pass performs exactly one write per bin, addresses 0 to 255 in ascending order; bin k is written in the cycle 11 + 10·k cycles after the cycle in which `start` was high.
- R7: `done` is high for exactly one cycle, the cycle after the write of bin 255.
- R8: A `start` pulse while a pass is running is ignored; the write order and timing of the running pass do not change.
- R9: `inverseMode` is sampled only with an accepted start; changing it during a pass has no effect on that pass.
- R10: A start in the cycle `done` is high (or later) is accepted and begins a new pass with the then-current `inverseMode`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Launch a pass over all bins |
| inverseMode | input | 1 | 1 = inverse-direction pre-stage, 0 = forward-direction post-stage |
| rdAddr | output | 8 | Input buffer read address |
| rdData | input | 32 | Input buffer word at `rdAddr`, same cycle {real, imag} |
| coefAddr | output | 8 | Coefficient store address (current bin) |
| coefA | input | 32 | Coefficient A at `coefAddr` {real, imag} |
| coefB | input | 32 | Coefficient B at `coefAddr` {real, imag} |
| wrEn | output | 1 | Output buffer write strobe |
| wrAddr | output | 8 | Output buffer write address |
| wrData | output | 32 | Result word {real, imag} |
| done | output | 1 | One-cycle pulse after the last write |

## Verification
The end of one pass and the start of the next can fall in the same cycle: the final write and the done pulse of a pass are still in flight while the controller is already idle and able to accept a new start. The bench drives `start` exactly in the cycle `done` is high, with the opposite direction selected, and judges that the done pulse and final result of the first pass are intact and that the second pass produces every bin of the other direction on the exact schedule. Stray starts and direction changes inside a running pass are injected separately and judged by the unchanged write stream.

// File: rtl/rfftSplitPkg.sv
package rfftSplitPkg;

  // multiply-accumulate steps per bin and total phases per bin (two reads first)
  localparam int STEPS  = 8;
  localparam int PHASES = STEPS + 2;

  // strobes from control to datapath
  typedef struct packed {
    logic       loadSelf;     // capture sample i from the read port
    logic       loadPartner;  // capture partner sample from the read port
    logic       macEn;        // one multiply-accumulate step
    logic [2:0] step;         // 0..3 real half, 4..7 imaginary half
    logic       inverse;      // direction latched at start
  } splitStrb_t;

endpackage

// File: rtl/rfftSplitCtrl.sv
module rfftSplitCtrl
  import rfftSplitPkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              start,
  input  logic              inverseMode,
  output splitStrb_t        strb,
  output logic [ADDR_W-1:0] binIdx,
  output logic [ADDR_W-1:0] rdAddr
);

  localparam int PH_W = $clog2(PHASES);
  localparam logic [PH_W-1:0] PH_LAST = PH_W'(PHASES - 1);

  logic            running;
  logic [PH_W-1:0] phase;
  logic [PH_W-1:0] stepFull;
  logic            modeReg;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      running <= 1'b0;
      phase   <= '0;
      binIdx  <= '0;
      modeReg <= 1'b0;
    end else if (!running) begin
      if (start) begin
        running <= 1'b1;
        phase   <= '0;
        binIdx  <= '0;
        modeReg <= inverseMode;
      end
    end else if (phase == PH_LAST) begin
      phase <= '0;
      if (binIdx == '1) running <= 1'b0;
      else              binIdx  <= binIdx + 1'b1;
    end else begin
      phase <= phase + 1'b1;
    end
  end

  always_comb begin
    stepFull         = phase - PH_W'(2);
    strb.loadSelf    = running && (phase == PH_W'(0));
    strb.loadPartner = running && (phase == PH_W'(1));
    strb.macEn       = running && (phase >= PH_W'(2));
    strb.step        = stepFull[2:0];
    strb.inverse     = modeReg;
    // partner index wraps modulo the bin count, so bin 0 pairs with itself
    rdAddr = (phase == PH_W'(1)) ? (ADDR_W'(0) - binIdx) : binIdx;
  end

  // R8: a start inside a pass does not disturb the sequence
  a_r8_start_ignored: assert property (@(posedge clk) disable iff (!rstN)
    (running && start && phase != PH_LAST) |=> (running && phase == $past(phase) + 1'b1 && $stable(binIdx)));

  // R9: the direction cannot change while a pass is running
  a_r9_mode_held: assert property (@(posedge clk) disable iff (!rstN)
    running |=> (!running || $stable(strb.inverse)));

endmodule

// File: rtl/rfftSplitDp.sv
module rfftSplitDp
  import rfftSplitPkg::*;
#(
  parameter int DATA_W = 16,
  parameter int COEF_W = 16,
  parameter int ADDR_W = 8
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  splitStrb_t            strb,
  input  logic [ADDR_W-1:0]     binIdx,
  input  logic [2*DATA_W-1:0]   rdData,
  input  logic [2*COEF_W-1:0]   coefA,
  input  logic [2*COEF_W-1:0]   coefB,
  output logic                  wrEn,
  output logic [ADDR_W-1:0]     wrAddr,
  output logic [2*DATA_W-1:0]   wrData,
  output logic                  done
);

  localparam int PROD_W = DATA_W + COEF_W;
  localparam int ACC_W  = PROD_W + 2;
  localparam int FRAC   = COEF_W - 1;
  localparam logic signed [ACC_W-1:0] HALF = ACC_W'(1) <<< (FRAC - 1);
  localparam logic signed [ACC_W-1:0] MAXV = ACC_W'((1 << (DATA_W - 1)) - 1);
  localparam logic signed [ACC_W-1:0] MINV = -MAXV - ACC_W'(1);

  logic signed [DATA_W-1:0] selfRe, selfIm, partRe, partIm, resRe;
  logic signed [COEF_W-1:0] aRe, aIm, bRe, bIm;
  logic signed [DATA_W-1:0] opData;
  logic signed [COEF_W-1:0] opCoef;
  logic signed [PROD_W-1:0] prod;
  logic signed [ACC_W-1:0]  termExt, term, accIn, sumNext, acc;
  logic signed [DATA_W-1:0] rounded;
  logic [1:0]               idx;
  logic                     imagHalf;
  logic [3:0]               negMask;

  function automatic logic signed [DATA_W-1:0] roundSat(input logic signed [ACC_W-1:0] s);
    logic signed [ACC_W-1:0] t;
    t = (s + HALF) >>> FRAC;
    if (t > MAXV)      roundSat = MAXV[DATA_W-1:0];
    else if (t < MINV) roundSat = MINV[DATA_W-1:0];
    else               roundSat = t[DATA_W-1:0];
  endfunction

  assign aRe = coefA[2*COEF_W-1:COEF_W];
  assign aIm = coefA[COEF_W-1:0];
  assign bRe = coefB[2*COEF_W-1:COEF_W];
  assign bIm = coefB[COEF_W-1:0];

  // operand order per half: self imag, self real, partner real, partner imag
  always_comb begin
    idx      = strb.step[1:0];
    imagHalf = strb.step[2];
    unique case (idx)
      2'd0:    opData = selfIm;
      2'd1:    opData = selfRe;
      2'd2:    opData = partRe;
      default: opData = partIm;
    endcase
    if (!imagHalf) begin
      unique case (idx)
        2'd0:    opCoef = aIm;
        2'd1:    opCoef = aRe;
        2'd2:    opCoef = bRe;
        default: opCoef = bIm;
      endcase
    end else begin
      unique case (idx)
        2'd0:    opCoef = aRe;
        2'd1:    opCoef = aIm;
        2'd2:    opCoef = bIm;
        default: opCoef = bRe;
      endcase
    end
    // subtracted terms, one bit per operand slot
    if (strb.inverse) negMask = imagHalf ? 4'b1110 : 4'b1000;
    else              negMask = imagHalf ? 4'b1000 : 4'b0001;
    prod    = opData * opCoef;
    termExt = $signed({{(ACC_W-PROD_W){prod[PROD_W-1]}}, prod});
    term    = negMask[idx] ? -termExt : termExt;
    if (idx == 2'd0) accIn = '0;
    else             accIn = acc;
    sumNext = accIn + term;
    rounded = roundSat(sumNext);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      selfRe <= '0; selfIm <= '0; partRe <= '0; partIm <= '0;
      acc    <= '0; resRe  <= '0;
      wrEn   <= 1'b0; wrAddr <= '0; wrData <= '0; done <= 1'b0;
    end else begin
      if (strb.loadSelf) begin
        selfRe <= rdData[2*DATA_W-1:DATA_W];
        selfIm <= rdData[DATA_W-1:0];
      end
      if (strb.loadPartner) begin
        partRe <= rdData[2*DATA_W-1:DATA_W];
        partIm <= rdData[DATA_W-1:0];
      end
      if (strb.macEn) acc <= sumNext;
      if (strb.macEn && strb.step == 3'd3) resRe <= rounded;
      wrEn <= strb.macEn && strb.step == 3'd7;
      if (strb.macEn && strb.step == 3'd7) begin
        wrAddr <= binIdx;
        wrData <= {resRe, rounded};
      end
      done <= wrEn && (wrAddr == '1);
    end
  end

  // R6: writes of consecutive bins are never adjacent
  a_r6_write_gap: assert property (@(posedge clk) disable iff (!rstN)
    wrEn |=> !wrEn);

  // R7: done is a single-cycle pulse
  a_r7_done_single: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  // R2: a written word is always fully defined
  a_r2_write_known: assert property (@(posedge clk) disable iff (!rstN)
    wrEn |-> !$isunknown({wrAddr, wrData}));

endmodule

// File: rtl/rfftSplit.sv
module rfftSplit
  import rfftSplitPkg::*;
#(
  parameter int DATA_W = 16,
  parameter int COEF_W = 16,
  parameter int ADDR_W = 8
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                start,
  input  logic                inverseMode,
  output logic [ADDR_W-1:0]   rdAddr,
  input  logic [2*DATA_W-1:0] rdData,
  output logic [ADDR_W-1:0]   coefAddr,
  input  logic [2*COEF_W-1:0] coefA,
  input  logic [2*COEF_W-1:0] coefB,
  output logic                wrEn,
  output logic [ADDR_W-1:0]   wrAddr,
  output logic [2*DATA_W-1:0] wrData,
  output logic                done
);

  splitStrb_t        strb;
  logic [ADDR_W-1:0] binIdx;

  assign coefAddr = binIdx;

  rfftSplitCtrl #(.ADDR_W(ADDR_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .start(start), .inverseMode(inverseMode),
    .strb(strb), .binIdx(binIdx), .rdAddr(rdAddr)
  );

  rfftSplitDp #(.DATA_W(DATA_W), .COEF_W(COEF_W), .ADDR_W(ADDR_W)) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .binIdx(binIdx),
    .rdData(rdData), .coefA(coefA), .coefB(coefB),
    .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData), .done(done)
  );

endmodule

// File: tb/rfftSplit_tb.sv
module rfftSplit_tb;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        start = 1'b0;
  logic        inverseMode = 1'b0;
  logic [7:0]  rdAddr, coefAddr, wrAddr;
  logic [31:0] rdData, coefA, coefB, wrData;
  logic        wrEn, done;

  logic signed [15:0] inRe [256];
  logic signed [15:0] inIm [256];
  logic signed [15:0] aRe [256];
  logic signed [15:0] aIm [256];
  logic signed [15:0] bRe [256];
  logic signed [15:0] bIm [256];
  logic signed [15:0] expRe [256];
  logic signed [15:0] expIm [256];

  int    cyc = 0;
  int    checks = 0;
  int    errors = 0;
  int    expAddr = 0;
  int    passCyc = 0;
  int    doneDue = -1;
  bit    armed = 0;
  bit    finished = 0;
  string passTag = "";

  always #5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  assign rdData = {inRe[rdAddr], inIm[rdAddr]};
  assign coefA  = {aRe[coefAddr], aIm[coefAddr]};
  assign coefB  = {bRe[coefAddr], bIm[coefAddr]};

  rfftSplit u_dut (
    .clk(clk), .rstN(rstN), .start(start), .inverseMode(inverseMode),
    .rdAddr(rdAddr), .rdData(rdData), .coefAddr(coefAddr),
    .coefA(coefA), .coefB(coefB),
    .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData), .done(done)
  );

  function automatic logic signed [15:0] satRound(input longint s);
    longint t;
    t = (s + 64'sd16384) >>> 15;
    if (t > 32767)  return 16'sh7fff;
    if (t < -32768) return 16'sh8000;
    return 16'(t);
  endfunction

  function automatic logic signed [15:0] quant(input real x);
    int v;
    v = $rtoi(x * 32768.0 + ((x >= 0.0) ? 0.5 : -0.5));
    if (v > 32767)  v = 32767;
    if (v < -32768) v = -32768;
    return 16'(v);
  endfunction

  // expected results written straight from the requirement formulas
  task automatic computeExpected(input bit inv);
    for (int i = 0; i < 256; i++) begin
      int p;
      longint xr, xi, pr, pi, ar, ai, br, bi, sr, si;
      p  = (256 - i) % 256;
      xr = inRe[i]; xi = inIm[i]; pr = inRe[p]; pi = inIm[p];
      ar = aRe[i];  ai = aIm[i];  br = bRe[i];  bi = bIm[i];
      if (inv) begin
        sr = xi*ai + xr*ar + pr*br - pi*bi;
        si = xi*ar - xr*ai - pr*bi - pi*br;
      end else begin
        sr = -xi*ai + xr*ar + pr*br + pi*bi;
        si = xi*ar + xr*ai + pr*bi - pi*br;
      end
      expRe[i] = satRound(sr);
      expIm[i] = satRound(si);
    end
  endtask

  task automatic fillTwiddle();
    for (int i = 0; i < 256; i++) begin
      real ang, c, s;
      ang = 2.0 * 3.14159265358979 * i / 512.0;
      c = $cos(ang); s = $sin(ang);
      aRe[i] = quant((1.0 - s) / 2.0); aIm[i] = quant(-c / 2.0);
      bRe[i] = quant((1.0 + s) / 2.0); bIm[i] = quant(c / 2.0);
    end
  endtask

  task automatic fillRandomData();
    for (int i = 0; i < 256; i++) begin
      inRe[i] = 16'($urandom);
      inIm[i] = 16'($urandom);
    end
    inRe[0] = 16'sd12345; inIm[0] = -16'sd7777;
  endtask

  // monitor: every write and every done pulse is a check
  always @(negedge clk) begin
    if (rstN && !finished) begin
      if (wrEn) begin
        checks++;
        if (!armed || expAddr > 255) begin
          errors++;
          $display("FAIL R6 %s: unexpected write addr=%0d data=%h expected no write", passTag, wrAddr, wrData);
        end else begin
          if (wrAddr != 8'(expAddr) || cyc != passCyc + 11 + 10*expAddr ||
              wrData != {expRe[expAddr], expIm[expAddr]}) begin
            errors++;
            $display("FAIL R6 %s: write addr=%0d cyc=%0d data=%h expected addr=%0d cyc=%0d data=%h",
                     passTag, wrAddr, cyc - passCyc, wrData, expAddr, 11 + 10*expAddr,
                     {expRe[expAddr], expIm[expAddr]});
          end
          if (expAddr == 255) doneDue = cyc + 1;
          expAddr++;
        end
      end
      if (done || cyc == doneDue) begin
        checks++;
        if (!(done && cyc == doneDue)) begin
          errors++;
          $display("FAIL R7 %s: done=%0b at cyc=%0d expected done=1 at cyc=%0d", passTag, done, cyc, doneDue);
        end
      end
    end
  end

  // call aligned just after a rising edge
  task automatic launch(input bit inv, input string tag);
    computeExpected(inv);
    passTag = tag;
    expAddr = 0;
    armed = 1;
    passCyc = cyc;
    inverseMode = inv;
    start = 1'b1;
    @(posedge clk); #1;
    start = 1'b0;
  endtask

  task automatic waitEnd(input int extra);
    while (cyc < passCyc + 2562 + extra) begin @(posedge clk); #1; end
    checks++;
    if (expAddr != 256) begin
      errors++;
      $display("FAIL R6 %s: writes=%0d expected 256", passTag, expAddr);
    end
  endtask

  task automatic testReset();
    repeat (20) @(posedge clk);
    #1;
    checks++;
    if (wrEn !== 1'b0 || done !== 1'b0) begin
      errors++;
      $display("FAIL R1: wrEn=%b done=%b expected 0 0", wrEn, done);
    end
  endtask

  task automatic testInverse();
    fillTwiddle(); fillRandomData();
    @(posedge clk); #1;
    launch(1'b1, "R2 R4 inverse");
    waitEnd(3);
  endtask

  task automatic testForward();
    fillRandomData();
    @(posedge clk); #1;
    launch(1'b0, "R3 R4 forward");
    waitEnd(3);
  endtask

  task automatic testModeFlip();
    fillRandomData();
    @(posedge clk); #1;
    launch(1'b1, "R9 mode flip");
    inverseMode = 1'b0;
    waitEnd(3);
  endtask

  task automatic testStrayStart();
    fillRandomData();
    @(posedge clk); #1;
    launch(1'b0, "R8 stray start");
    repeat (500) @(posedge clk);
    #1 start = 1'b1;
    @(posedge clk); #1 start = 1'b0;
    repeat (1234) @(posedge clk);
    #1 start = 1'b1;
    @(posedge clk); #1 start = 1'b0;
    waitEnd(3);
  endtask

  task automatic testSaturate();
    for (int i = 0; i < 256; i++) begin
      if (i < 128) begin
        aRe[i] = (i % 2) ? 16'sh7fff : 16'sh8000; aIm[i] = (i % 3 == 0) ? 16'sh7fff : 16'sh8000;
        bRe[i] = 16'sh7fff; bIm[i] = (i % 2) ? 16'sh8000 : 16'sh7fff;
        inRe[i] = (i % 2) ? 16'sh7fff : 16'sh8000; inIm[i] = (i % 4 < 2) ? 16'sh8000 : 16'sh7fff;
      end else begin
        aRe[i] = 16'sd16384; aIm[i] = 16'sd16384; bRe[i] = 16'sd16384; bIm[i] = -16'sd16384;
        inRe[i] = (i % 2) ? -16'sd1 : 16'sd1; inIm[i] = 16'((i % 3) - 1);
      end
    end
    @(posedge clk); #1;
    launch(1'b1, "R5 round and clamp");
    waitEnd(3);
  endtask

  task automatic testBackToBack();
    fillTwiddle(); fillRandomData();
    @(posedge clk); #1;
    launch(1'b0, "R10 first pass");
    while (cyc < passCyc + 2562) begin @(posedge clk); #1; end
    checks++;
    if (done !== 1'b1) begin
      errors++;
      $display("FAIL R10: done=%b in start cycle expected 1", done);
    end
    launch(1'b1, "R10 second pass");
    waitEnd(3);
  endtask

  initial begin
    repeat (4) @(posedge clk);
    #1 rstN = 1'b1;
    testReset();
    testInverse();
    testForward();
    testModeFlip();
    testStrayStart();
    testSaturate();
    testBackToBack();
    repeat (20) @(posedge clk);
    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      errors++;
      checks++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule